// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Unit

This block holds the main translation table of a memory management unit and gives software a small register-level command interface to it. Software fills two descriptor registers, DESC0 (virtual page number, present flag, spare flags and an 8-bit address-space tag) and DESC1 (physical frame and permissions, stored opaquely), and may set a slot register. It then issues one command: search, pick a slot, store an entry with or without flushing the companion micro-translation buffers, load an entry back into the descriptors, or flush the micro buffers alone. The result of a command appears in the slot register or the descriptor registers. A one-cycle flush pulse goes to the micro buffers.

The table is `SETS` sets of `WAYS` ways, with 128 x 2 as the default. The set is chosen by the lowest `log2(SETS)` bits of the virtual page number. Register writes arrive on a valid/ready channel. `wr_ready_o` is low only while a command executes, so a sender holds `wr_sel_i` and `wr_data_i` stable until the handshake completes. A register write that is not a command completes in one cycle and never stalls the channel.

Top module: `tlbc_unit`

## Requirements
- R1: After reset the slot register, both descriptor registers, `busy_o` and `utlb_inv_o` read as zero, and every table entry is empty.
- R2: A write to the command register (select 3) raises `busy_o` and drops `wr_ready_o` for exactly the following cycle. The command's results are visible from the cycle after that. Writes to select 0 (DESC0), 1 (DESC1) and 2 (slot) never raise `busy_o`.
- R3: Search (code 1) compares DESC0 bits [31:13] and [7:0] against each present entry of the selected set. On a single match the slot register holds the linear slot with bit 31 clear. On no match it reads 0x8000_0000.
- R4: When a search matches more than one way, the slot register reads 0x8000_0001: the error flag in bit 31 and the duplicate mark in bit 0.
- R5: Pick-slot (code 2) loads the matching slot when DESC0 already hits. Otherwise it loads the slot of the set's round-robin victim way and then advances that set's pointer. A hit leaves the pointer unchanged.
- R6: Store (code 3) writes DESC0 and DESC1 into the entry at the slot register and pulses `utlb_inv_o` for one cycle. When bit 31 of the slot register is set, the table is left unchanged but the pulse still occurs.
- R7: Store-keep (code 4) writes the entry like code 3 but leaves `utlb_inv_o` low.
- R8: Load (code 5) copies the entry at the slot register into DESC0 and DESC1 and leaves the slot register unchanged.
- R9: Micro-flush (code 6) pulses `utlb_inv_o` for one cycle and changes neither the table nor any register.
- R10: An entry counts as valid only when its DESC0 bit 8 is set. Storing all-zero descriptors erases an entry, and an entry with bit 8 clear is never matched.
- R11: The linear slot equals set x WAYS + way, so the ways of one set are consecutive. The set is taken from DESC0 bits starting at bit 13.
- R12: Codes 0 and 7 change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Register write request |
| wr_ready_o | output | 1 | Register write accepted when high with valid |
| wr_sel_i | input | 2 | 0 DESC0, 1 DESC1, 2 slot, 3 command |
| wr_data_i | input | 32 | Write data; command code in bits [2:0] |
| pd0_o | output | 32 | DESC0 register |
| pd1_o | output | 32 | DESC1 register |
| index_o | output | 32 | Slot register: bit 31 error, low bits slot or duplicate mark |
| busy_o | output | 1 | Command executing |
| utlb_inv_o | output | 1 | One-cycle micro-buffer flush pulse |

## Verification
The search is tried with an empty set, with a key that differs only in its address-space tag, with an exact single match and with two ways holding the same key. These cases separate the miss, hit and duplicate encodings. Pick-slot is run on a miss, on a second miss in the same set, on a hit and on a miss in another set. This sequence shows that the victim pointer is kept per set, that it wraps, and that a hit does not advance it. Store with the error flag set, entries whose present bit is clear, and erase-by-zero are each read back through a search or a load, so that table changes are observed only at the ports.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

  localparam int DESC_W      = 32;
  localparam int TAG_W       = 8;
  localparam int PRESENT_BIT = 8;
  localparam int ERR_BIT     = 31;

  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_SEARCH     = 3'd1,
    CMD_PICK       = 3'd2,
    CMD_STORE      = 3'd3,
    CMD_STORE_KEEP = 3'd4,
    CMD_LOAD       = 3'd5,
    CMD_UFLUSH     = 3'd6
  } tlb_cmd_e;

  typedef enum logic [1:0] {
    SEL_DESC0 = 2'd0,
    SEL_DESC1 = 2'd1,
    SEL_SLOT  = 2'd2,
    SEL_CMD   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/tlbc_store.sv
module tlbc_store #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   we_i,
  input  logic [SET_W-1:0]                       wr_set_i,
  input  logic [WAY_W-1:0]                       wr_way_i,
  input  logic [tlbc_pkg::DESC_W-1:0]            wr_pd0_i,
  input  logic [tlbc_pkg::DESC_W-1:0]            wr_pd1_i,
  input  logic [SET_W-1:0]                       lk_set_i,
  output logic [WAYS-1:0][tlbc_pkg::DESC_W-1:0]  lk_pd0_o,
  input  logic [SET_W-1:0]                       rd_set_i,
  input  logic [WAY_W-1:0]                       rd_way_i,
  output logic [tlbc_pkg::DESC_W-1:0]            rd_pd0_o,
  output logic [tlbc_pkg::DESC_W-1:0]            rd_pd1_o
);
  import tlbc_pkg::*;

  logic [WAYS-1:0][DESC_W-1:0] way_rd0;
  logic [WAYS-1:0][DESC_W-1:0] way_rd1;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DESC_W-1:0] pd0_q [SETS];
    logic [DESC_W-1:0] pd1_q [SETS];
    logic              sel_w;

    assign sel_w = we_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          pd0_q[s] <= '0;
          pd1_q[s] <= '0;
        end
      end else if (sel_w) begin
        pd0_q[wr_set_i] <= wr_pd0_i;
        pd1_q[wr_set_i] <= wr_pd1_i;
      end
    end

    assign lk_pd0_o[w] = pd0_q[lk_set_i];
    assign way_rd0[w]  = pd0_q[rd_set_i];
    assign way_rd1[w]  = pd1_q[rd_set_i];
  end

  assign rd_pd0_o = way_rd0[rd_way_i];
  assign rd_pd1_o = way_rd1[rd_way_i];

endmodule

// File: rtl/tlbc_match.sv
module tlbc_match #(
  parameter int WAYS     = 2,
  parameter int PG_SHIFT = 13,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic [tlbc_pkg::DESC_W-1:0]           key_i,
  input  logic [WAYS-1:0][tlbc_pkg::DESC_W-1:0] ent_i,
  output logic                                  hit_o,
  output logic                                  dup_o,
  output logic [WAY_W-1:0]                      way_o
);
  import tlbc_pkg::*;

  localparam logic [DESC_W-1:0] VPN_MASK = ~((DESC_W'(1) << PG_SHIFT) - DESC_W'(1));
  localparam logic [DESC_W-1:0] TAG_MASK = (DESC_W'(1) << TAG_W) - DESC_W'(1);
  localparam logic [DESC_W-1:0] CMP_MASK = VPN_MASK | TAG_MASK;

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = ent_i[w][PRESENT_BIT] && (((ent_i[w] ^ key_i) & CMP_MASK) == '0);
  end

  always_comb begin
    int cnt;
    cnt   = 0;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        cnt   = cnt + 1;
        way_o = WAY_W'(w);
      end
    end
    hit_o = (cnt != 0);
    dup_o = (cnt > 1);
  end

endmodule

// File: rtl/tlbc_victim.sv
module tlbc_victim #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [SET_W-1:0] set_i,
  output logic [WAY_W-1:0] way_o
);

  logic [WAY_W-1:0] rr_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (adv_i) begin
      if (rr_q[set_i] == WAY_W'(WAYS - 1)) rr_q[set_i] <= '0;
      else                                 rr_q[set_i] <= rr_q[set_i] + 1'b1;
    end
  end

  assign way_o = rr_q[set_i];

  // R5: each miss-driven pick moves that set's pointer on
  a_r5_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (rr_q[$past(set_i)] != $past(rr_q[set_i])));

endmodule

// File: rtl/tlbc_unit.sv
module tlbc_unit #(
  parameter int SETS     = 128,
  parameter int WAYS     = 2,
  parameter int PG_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid_i,
  output logic        wr_ready_o,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] pd0_o,
  output logic [31:0] pd1_o,
  output logic [31:0] index_o,
  output logic        busy_o,
  output logic        utlb_inv_o
);
  import tlbc_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = SET_W + WAY_W;
  localparam int PAD_W = DESC_W - 1 - IDX_W;

  logic [DESC_W-1:0] pd0_q, pd1_q;
  logic [IDX_W-1:0]  idx_q;
  logic              err_q;
  logic              exec_q;
  tlb_cmd_e          cmd_q;
  logic              inv_q;

  logic                        acc;
  logic [SET_W-1:0]            lk_set;
  logic [WAYS-1:0][DESC_W-1:0] lk_pd0;
  logic [DESC_W-1:0]           rd_pd0, rd_pd1;
  logic                        hit, dup;
  logic [WAY_W-1:0]            hit_way, vic_way;
  logic                        st_we, vic_adv;
  logic [SET_W-1:0]            slot_set;
  logic [WAY_W-1:0]            slot_way;

  assign wr_ready_o = !exec_q;
  assign acc        = wr_valid_i && wr_ready_o;
  assign lk_set     = pd0_q[PG_SHIFT +: SET_W];
  assign slot_set   = idx_q[IDX_W-1:WAY_W];
  assign slot_way   = idx_q[WAY_W-1:0];

  assign st_we   = exec_q && !err_q && ((cmd_q == CMD_STORE) || (cmd_q == CMD_STORE_KEEP));
  assign vic_adv = exec_q && (cmd_q == CMD_PICK) && !hit;

  tlbc_store #(.SETS(SETS), .WAYS(WAYS)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (st_we),
    .wr_set_i (slot_set),
    .wr_way_i (slot_way),
    .wr_pd0_i (pd0_q),
    .wr_pd1_i (pd1_q),
    .lk_set_i (lk_set),
    .lk_pd0_o (lk_pd0),
    .rd_set_i (slot_set),
    .rd_way_i (slot_way),
    .rd_pd0_o (rd_pd0),
    .rd_pd1_o (rd_pd1)
  );

  tlbc_match #(.WAYS(WAYS), .PG_SHIFT(PG_SHIFT)) i_match (
    .key_i (pd0_q),
    .ent_i (lk_pd0),
    .hit_o (hit),
    .dup_o (dup),
    .way_o (hit_way)
  );

  tlbc_victim #(.SETS(SETS), .WAYS(WAYS)) i_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (vic_adv),
    .set_i (lk_set),
    .way_o (vic_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd0_q  <= '0;
      pd1_q  <= '0;
      idx_q  <= '0;
      err_q  <= 1'b0;
      exec_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      inv_q  <= 1'b0;
    end else begin
      inv_q  <= 1'b0;
      exec_q <= 1'b0;
      if (acc) begin
        case (reg_sel_e'(wr_sel_i))
          SEL_DESC0: pd0_q <= wr_data_i;
          SEL_DESC1: pd1_q <= wr_data_i;
          SEL_SLOT: begin
            err_q <= wr_data_i[ERR_BIT];
            idx_q <= wr_data_i[IDX_W-1:0];
          end
          default: begin
            exec_q <= 1'b1;
            cmd_q  <= tlb_cmd_e'(wr_data_i[2:0]);
          end
        endcase
      end
      if (exec_q) begin
        case (cmd_q)
          CMD_SEARCH: begin
            if (hit && !dup) begin
              err_q <= 1'b0;
              idx_q <= {lk_set, hit_way};
            end else begin
              err_q <= 1'b1;
              idx_q <= IDX_W'(dup);
            end
          end
          CMD_PICK: begin
            err_q <= 1'b0;
            idx_q <= hit ? {lk_set, hit_way} : {lk_set, vic_way};
          end
          CMD_STORE:  inv_q <= 1'b1;
          CMD_UFLUSH: inv_q <= 1'b1;
          CMD_LOAD: begin
            if (!err_q) begin
              pd0_q <= rd_pd0;
              pd1_q <= rd_pd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pd0_o      = pd0_q;
  assign pd1_o      = pd1_q;
  assign index_o    = {err_q, {PAD_W{1'b0}}, idx_q};
  assign busy_o     = exec_q;
  assign utlb_inv_o = inv_q;

  // R2: a command occupies exactly one busy cycle
  a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |=> !busy_o);

  // R2: an accepted command write makes the unit busy next cycle
  a_r2_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o && (wr_sel_i == 2'd3)) |=> busy_o);

  // R6: a store always flushes the micro buffers
  a_r6_store_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && (cmd_q == CMD_STORE)) |=> utlb_inv_o);

  // R7: store-keep leaves the micro buffers alone
  a_r7_keep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && (cmd_q == CMD_STORE_KEEP)) |=> !utlb_inv_o);

  // R12: unused codes touch no visible register
  a_r12_nop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && ((cmd_q == CMD_NOP) || (cmd_q == tlb_cmd_e'(3'd7))))
      |=> ($stable(index_o) && $stable(pd0_o) && $stable(pd1_o) && !utlb_inv_o));

endmodule

// File: tb/test_tlbc_unit.sv
`timescale 1ns/1ps
module test_tlbc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pd0, pd1, index;
  logic        busy, uinv;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tlbc_unit i_tlbc_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid),
    .wr_ready_o (wr_ready),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .pd0_o      (pd0),
    .pd1_o      (pd1),
    .index_o    (index),
    .busy_o     (busy),
    .utlb_inv_o (uinv)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] data;
    logic        chk;
    logic [31:0] exp_idx;
    logic        exp_inv;
    logic [7:0]  req;
  } row_t;

  localparam row_t TBL [18] = '{
    '{2'd0, 32'h0000_2105, 1'b0, 32'h0,          1'b0, 8'd3 },
    '{2'd3, 32'd1,         1'b1, 32'h8000_0000,  1'b0, 8'd3 },  // R3 empty set misses
    '{2'd3, 32'd2,         1'b1, 32'h0000_0002,  1'b0, 8'd11},  // R11 set 1 way 0
    '{2'd1, 32'h1234_5007, 1'b0, 32'h0,          1'b0, 8'd6 },
    '{2'd3, 32'd3,         1'b1, 32'h0000_0002,  1'b1, 8'd6 },  // R6 store pulses
    '{2'd3, 32'd1,         1'b1, 32'h0000_0002,  1'b0, 8'd3 },  // R3 hit
    '{2'd0, 32'h0000_2106, 1'b0, 32'h0,          1'b0, 8'd3 },
    '{2'd3, 32'd1,         1'b1, 32'h8000_0000,  1'b0, 8'd3 },  // R3 tag differs
    '{2'd3, 32'd2,         1'b1, 32'h0000_0003,  1'b0, 8'd5 },  // R5 next victim
    '{2'd1, 32'h0ABC_0003, 1'b0, 32'h0,          1'b0, 8'd7 },
    '{2'd3, 32'd4,         1'b1, 32'h0000_0003,  1'b0, 8'd7 },  // R7 no pulse
    '{2'd3, 32'd2,         1'b1, 32'h0000_0003,  1'b0, 8'd5 },  // R5 hit, no advance
    '{2'd0, 32'h0000_4105, 1'b0, 32'h0,          1'b0, 8'd11},
    '{2'd3, 32'd2,         1'b1, 32'h0000_0004,  1'b0, 8'd11},  // R11 set 2 own pointer
    '{2'd0, 32'h0000_2107, 1'b0, 32'h0,          1'b0, 8'd5 },
    '{2'd3, 32'd2,         1'b1, 32'h0000_0002,  1'b0, 8'd5 },  // R5 pointer wraps
    '{2'd3, 32'd6,         1'b1, 32'h0000_0002,  1'b1, 8'd9 },  // R9 flush pulse
    '{2'd3, 32'd7,         1'b1, 32'h0000_0002,  1'b0, 8'd12}   // R12 unused code
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_sel   = sel;
    wr_data  = d;
    wr_valid = 1'b1;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] c);
    wr(2'd3, {29'b0, c});
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 index", index, 32'h0);
    check("R1 pd0", pd0, 32'h0);
    check("R1 pd1", pd1, 32'h0);
    check("R1 busy/inv", {30'b0, busy, uinv}, 32'h0);

    for (int i = 0; i < 18; i++) begin
      if (TBL[i].sel == 2'd3) cmd(TBL[i].data[2:0]);
      else                    wr(TBL[i].sel, TBL[i].data);
      if (TBL[i].chk) begin
        check($sformatf("R%0d row %0d index", TBL[i].req, i), index, TBL[i].exp_idx);
        check($sformatf("R%0d row %0d pulse", TBL[i].req, i), {31'b0, uinv}, {31'b0, TBL[i].exp_inv});
      end
    end

    // R8 load slot 3 back
    wr(2'd2, 32'd3);
    cmd(3'd5);
    check("R8 pd0", pd0, 32'h0000_2106);
    check("R8 pd1", pd1, 32'h0ABC_0003);
    check("R8 index kept", index, 32'h3);

    // R9 flush left the table intact
    wr(2'd0, 32'h0000_2105);
    cmd(3'd1);
    check("R9 entry kept", index, 32'h2);

    // R4 duplicate in set 1
    wr(2'd2, 32'd3);
    wr(2'd1, 32'h1);
    cmd(3'd3);
    cmd(3'd1);
    check("R4 duplicate", index, 32'h8000_0001);

    // R10 erase slot 3, duplicate gone
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd3);
    cmd(3'd3);
    wr(2'd0, 32'h0000_2105);
    cmd(3'd1);
    check("R10 erase", index, 32'h2);

    // R10 entry without present bit never matches
    wr(2'd0, 32'h0000_2005);
    wr(2'd2, 32'd2);
    cmd(3'd3);
    wr(2'd0, 32'h0000_2105);
    cmd(3'd1);
    check("R10 not present", index, 32'h8000_0000);

    // R6 store with error flag leaves slot 0 empty but still pulses
    wr(2'd0, 32'h0000_6105);
    wr(2'd1, 32'h5555_5555);
    cmd(3'd3);
    check("R6 flag pulse", {31'b0, uinv}, 32'h1);
    wr(2'd2, 32'd0);
    cmd(3'd5);
    check("R6 flag blocks pd0", pd0, 32'h0);
    check("R6 flag blocks pd1", pd1, 32'h0);

    // R2 busy window and non-command writes
    wr(2'd1, 32'h7);
    @(negedge clk);
    check("R2 reg write no busy", {31'b0, busy}, 32'h0);
    wr(2'd3, 32'd0);
    @(negedge clk);
    check("R2 busy", {30'b0, busy, wr_ready}, 32'h2);
    @(negedge clk);
    check("R2 idle", {30'b0, busy, wr_ready}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule